// File: doc/BRIEF.md
# Over-Current Alarm Throttler

This block watches an asynchronous over-current alarm line coming from off-chip. The line can be wired as active-high or as active-low. The block synchronises the line, makes its polarity uniform and counts every transition from quiet to alarm as one event. When the number of events reaches a programmed threshold, it sets a sticky interrupt flag. While the alarm is present it drives a throttle request to the downstream clock-skipping logic, and it keeps that request up for a programmed number of microseconds after the alarm goes away.

A quiet-time filter, measured in clocks, empties the event counter when no event has arrived for the whole window. The filter then starts again on its own. The counter therefore tracks bursts of alarms and ignores isolated glitches spread over a long time. A prescale input gives the number of clocks in one microsecond, so the hold time can be set in real time units. All configuration arrives on plain inputs that are decoded elsewhere.

Top module: `oc_alarm_throttler`

## Requirements
- R1: With `cfg_active_low`=1 a low level on `alarm_pin` is an alarm; with it at 0 a high level is an alarm. `throttle_req` follows a pin change after two clock edges.
- R2: Each quiet-to-alarm transition of the synchronised, polarity-corrected alarm adds one to `event_count`. The count saturates at all ones.
- R3: With `cfg_irq_en`=1, the event that brings the count up to `cfg_threshold` sets `irq`, and `event_count` returns to 0 in the same cycle.
- R4: With `cfg_threshold`=0 and `cfg_irq_en`=1, every event sets `irq`.
- R5: With `cfg_irq_en`=0, `irq` never rises, whatever the threshold.
- R6: `irq` stays set until a one-cycle `irq_clear` pulse. If a new interrupt and a clear happen in the same cycle, the interrupt wins.
- R7: With `cfg_filter_clks`=N>0, N clocks without an event empty `event_count`, and the quiet timer then starts again.
- R8: With `cfg_filter_clks`=0 the count is never emptied by time.
- R9: `throttle_req` is high while the alarm is present and for `cfg_hold_us`×`cfg_clk_per_us` clocks after it ends. A prescale of 0 acts as 1.
- R10: With `cfg_hold_us`=0, `throttle_req` drops in the same cycle as the synchronised alarm.
- R11: If the alarm comes back during the hold, the hold time starts again in full from the next release.
- R12: After reset `irq`=0, `throttle_req`=0 and `event_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_pin | input | 1 | Raw, asynchronous over-current alarm |
| cfg_active_low | input | 1 | 1: low level is an alarm |
| cfg_irq_en | input | 1 | Enables the interrupt |
| cfg_threshold | input | CNT_W | Event count that raises the interrupt |
| cfg_filter_clks | input | FILT_W | Quiet window in clocks, 0 = off |
| cfg_hold_us | input | HOLD_W | Throttle hold after release, in microseconds |
| cfg_clk_per_us | input | PRE_W | Clocks per microsecond |
| irq_clear | input | 1 | One-cycle clear of the interrupt flag |
| irq | output | 1 | Sticky interrupt flag |
| throttle_req | output | 1 | Throttle request to downstream logic |
| event_count | output | CNT_W | Current event count |

## Verification
A wrong event counter shows up on `event_count` within two cycles of the alarm edge. It also shows up as an `irq` that rises one event early or late against the bench's own threshold model. A quiet timer that is off by one, or that never clears the counter, is caught by samples of the count a few cycles before and after the filter window ends. Errors in the hold or prescale counters appear on `throttle_req` as a release that comes too early or too late, or that does not restart, measured against the exact product of hold time and prescale.

// File: rtl/oc_throt_pkg.sv
package oc_throt_pkg;
   parameter int unsigned DEF_CNT_W  = 8;
   parameter int unsigned DEF_FILT_W = 16;
   parameter int unsigned DEF_HOLD_W = 12;
   parameter int unsigned DEF_PRE_W  = 8;
   parameter int unsigned DEF_SYNC   = 2;
endpackage

// File: rtl/oc_alarm_sync.sv
module oc_alarm_sync #(
   parameter int unsigned STAGES = oc_throt_pkg::DEF_SYNC
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic active_low,
   output logic act,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              act_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("oc_alarm_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         act_q <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], pin ^ active_low};
         act_q <= chain[STAGES-1];
      end
   end

   assign act  = chain[STAGES-1];
   assign rise = act & ~act_q;

   a_r2_single_cycle_event: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/oc_event_counter.sv
module oc_event_counter #(
   parameter int unsigned CNT_W  = oc_throt_pkg::DEF_CNT_W,
   parameter int unsigned FILT_W = oc_throt_pkg::DEF_FILT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              irq_en,
   input  logic [CNT_W-1:0]  threshold,
   input  logic [FILT_W-1:0] filter_clks,
   input  logic              irq_clear,
   output logic              irq,
   output logic [CNT_W-1:0]  count
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [FILT_W-1:0] quiet;
   logic [CNT_W:0]    cnt_inc;
   logic              irq_set;
   logic              filt_on;
   logic              filt_hit;

   generate
      if (CNT_W < 1 || FILT_W < 1) begin : g_bad
         $error("oc_event_counter: widths must be positive");
      end
   endgenerate

   assign cnt_inc  = {1'b0, count} + (CNT_W+1)'(1);
   assign irq_set  = rise && irq_en && (cnt_inc >= {1'b0, threshold});
   assign filt_on  = (filter_clks != '0);
   assign filt_hit = !rise && filt_on && (quiet == filter_clks - FILT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet <= '0;
      end else if (rise || !filt_on || filt_hit) begin
         quiet <= '0;
      end else begin
         quiet <= quiet + FILT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (irq_set) begin
         count <= '0;
      end else if (rise) begin
         if (count != CNT_MAX) count <= count + CNT_W'(1);
      end else if (filt_hit) begin
         count <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq <= 1'b0;
      else if (irq_set)   irq <= 1'b1;
      else if (irq_clear) irq <= 1'b0;
   end

   a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clear) |=> irq);
   a_r6_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clear && !rise) |=> !irq);
   a_r5_no_irq_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !irq_en) |=> !irq);
   a_r7_quiet_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> (count <= $past(count)));
endmodule

// File: rtl/oc_hold_timer.sv
module oc_hold_timer #(
   parameter int unsigned HOLD_W = oc_throt_pkg::DEF_HOLD_W,
   parameter int unsigned PRE_W  = oc_throt_pkg::DEF_PRE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act,
   input  logic [HOLD_W-1:0] hold_us,
   input  logic [PRE_W-1:0]  clk_per_us,
   output logic              throttle_req
);
   logic [HOLD_W-1:0] remain;
   logic [PRE_W-1:0]  pre;
   logic              us_tick;

   generate
      if (HOLD_W < 1 || PRE_W < 1) begin : g_bad
         $error("oc_hold_timer: widths must be positive");
      end
   endgenerate

   assign us_tick = (clk_per_us <= PRE_W'(1)) || (pre == clk_per_us - PRE_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
         pre    <= '0;
      end else if (act) begin
         remain <= hold_us;
         pre    <= '0;
      end else if (remain != '0) begin
         if (us_tick) begin
            pre    <= '0;
            remain <= remain - HOLD_W'(1);
         end else begin
            pre <= pre + PRE_W'(1);
         end
      end
   end

   assign throttle_req = act | (remain != '0);

   a_r10_no_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(act) && ($past(hold_us) == '0)) |-> !throttle_req);
   a_r9_hold_engaged: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(act) && ($past(hold_us) != '0)) |-> throttle_req);
endmodule

// File: rtl/oc_alarm_throttler.sv
module oc_alarm_throttler #(
   parameter int unsigned CNT_W  = oc_throt_pkg::DEF_CNT_W,
   parameter int unsigned FILT_W = oc_throt_pkg::DEF_FILT_W,
   parameter int unsigned HOLD_W = oc_throt_pkg::DEF_HOLD_W,
   parameter int unsigned PRE_W  = oc_throt_pkg::DEF_PRE_W,
   parameter int unsigned SYNC   = oc_throt_pkg::DEF_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alarm_pin,
   input  logic              cfg_active_low,
   input  logic              cfg_irq_en,
   input  logic [CNT_W-1:0]  cfg_threshold,
   input  logic [FILT_W-1:0] cfg_filter_clks,
   input  logic [HOLD_W-1:0] cfg_hold_us,
   input  logic [PRE_W-1:0]  cfg_clk_per_us,
   input  logic              irq_clear,
   output logic              irq,
   output logic              throttle_req,
   output logic [CNT_W-1:0]  event_count
);
   logic act;
   logic rise;

   oc_alarm_sync #(.STAGES(SYNC)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(alarm_pin), .active_low(cfg_active_low),
      .act(act), .rise(rise)
   );

   oc_event_counter #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .rise(rise), .irq_en(cfg_irq_en),
      .threshold(cfg_threshold), .filter_clks(cfg_filter_clks),
      .irq_clear(irq_clear), .irq(irq), .count(event_count)
   );

   oc_hold_timer #(.HOLD_W(HOLD_W), .PRE_W(PRE_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .act(act), .hold_us(cfg_hold_us),
      .clk_per_us(cfg_clk_per_us), .throttle_req(throttle_req)
   );

   a_r3_irq_empties_count: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (event_count == '0));
endmodule

// File: tb/sim_oc_alarm_throttler.sv
module sim_oc_alarm_throttler;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alarm_pin = 1'b0;
   logic        cfg_active_low = 1'b0;
   logic        cfg_irq_en = 1'b0;
   logic [7:0]  cfg_threshold = 8'd0;
   logic [15:0] cfg_filter_clks = 16'd0;
   logic [11:0] cfg_hold_us = 12'd0;
   logic [7:0]  cfg_clk_per_us = 8'd1;
   logic        irq_clear = 1'b0;
   logic        irq;
   logic        throttle_req;
   logic [7:0]  event_count;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   oc_alarm_throttler u0 (
      .clk(clk), .rst_n(rst_n), .alarm_pin(alarm_pin),
      .cfg_active_low(cfg_active_low), .cfg_irq_en(cfg_irq_en),
      .cfg_threshold(cfg_threshold), .cfg_filter_clks(cfg_filter_clks),
      .cfg_hold_us(cfg_hold_us), .cfg_clk_per_us(cfg_clk_per_us),
      .irq_clear(irq_clear), .irq(irq), .throttle_req(throttle_req),
      .event_count(event_count)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_alarm(input bit on);
      alarm_pin = on ^ cfg_active_low;
   endtask

   task automatic pulse(input int hi, input int lo);
      set_alarm(1'b1); tick(hi);
      set_alarm(1'b0); tick(lo);
   endtask

   task automatic do_reset(input bit low_pol);
      rst_n = 1'b0;
      cfg_active_low = low_pol;
      alarm_pin = low_pol;
      tick(3);
      rst_n = 1'b1;
      tick(3);
   endtask

   task automatic clear_irq();
      irq_clear = 1'b1; tick(1); irq_clear = 1'b0;
   endtask

   // bench model of the interrupt counter
   function automatic int model_next(input int cnt, input int thr, input bit en,
                                     output bit fire);
      fire = en && (cnt + 1 >= thr);
      if (fire) return 0;
      return (cnt == 255) ? 255 : cnt + 1;
   endfunction

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      do_reset(1'b0);
      // R12 reset state
      check("R12 irq", irq, 0);
      check("R12 throttle", throttle_req, 0);
      check("R12 count", event_count, 0);

      // R1 active-high: two edges of latency
      set_alarm(1'b1); tick(1);
      check("R1 latency", throttle_req, 0);
      tick(1);
      check("R1 high alarm", throttle_req, 1);
      set_alarm(1'b0); tick(4);
      check("R2 one event", event_count, 1);

      // R2 saturation, interrupt disabled, no filter
      for (int i = 0; i < 260; i++) pulse(3, 4);
      check("R2 saturate", event_count, 255);
      check("R5 no irq while disabled", irq, 0);

      // R5 zero threshold with irq disabled still silent
      cfg_threshold = 8'd0;
      pulse(3, 4);
      check("R5 thr0 disabled", irq, 0);

      // R4 threshold 0, enabled: every event
      cfg_irq_en = 1'b1;
      pulse(3, 4);
      check("R4 irq on event", irq, 1);
      check("R3 count emptied", event_count, 0);
      clear_irq(); tick(1);
      check("R6 cleared", irq, 0);
      pulse(3, 4);
      check("R4 irq second event", irq, 1);

      // R6 sticky
      tick(50);
      check("R6 sticky", irq, 1);
      clear_irq();

      // R6 set wins over clear in same cycle
      cfg_threshold = 8'd1;
      set_alarm(1'b1); tick(2);
      irq_clear = 1'b1; tick(1); irq_clear = 1'b0;
      check("R6 set wins", irq, 1);
      set_alarm(1'b0); tick(4);
      clear_irq(); tick(1);

      // R3 random thresholds vs model
      begin
         int mcnt = event_count;
         for (int i = 0; i < 40; i++) begin
            bit fire;
            int thr = 1 + $urandom_range(4);
            if (i % 8 == 0) begin
               cfg_threshold = 8'(thr);
            end
            mcnt = model_next(mcnt, cfg_threshold, 1'b1, fire);
            pulse(3 + $urandom_range(3), 4 + $urandom_range(4));
            check("R3 random count", event_count, mcnt);
            check("R3 random irq", irq, fire);
            if (irq) clear_irq();
         end
      end

      // R7 filter window
      cfg_irq_en = 1'b0;
      cfg_filter_clks = 16'd20;
      tick(30);
      check("R7 idle empty", event_count, 0);
      set_alarm(1'b1); tick(3); set_alarm(1'b0);
      tick(16);
      check("R7 before window", event_count, 1);
      tick(6);
      check("R7 after window", event_count, 0);
      // filter re-arms
      pulse(3, 4); pulse(3, 4);
      check("R7 rearmed count", event_count, 2);
      tick(25);
      check("R7 rearmed clear", event_count, 0);

      // R8 filter off
      cfg_filter_clks = 16'd0;
      pulse(3, 4); pulse(3, 4); pulse(3, 4);
      tick(400);
      check("R8 no clearing", event_count, 3);

      // R9 hold 5 us at 3 clk/us = 15 clocks
      cfg_hold_us = 12'd5; cfg_clk_per_us = 8'd3;
      set_alarm(1'b1); tick(5); set_alarm(1'b0);
      tick(16);
      check("R9 held", throttle_req, 1);
      tick(2);
      check("R9 released", throttle_req, 0);

      // R11 restart during hold
      set_alarm(1'b1); tick(5); set_alarm(1'b0);
      tick(10);
      set_alarm(1'b1); tick(4); set_alarm(1'b0);
      tick(16);
      check("R11 restarted hold", throttle_req, 1);
      tick(2);
      check("R11 release", throttle_req, 0);

      // R9 prescale 0 acts as 1: 4 clocks
      cfg_hold_us = 12'd4; cfg_clk_per_us = 8'd0;
      set_alarm(1'b1); tick(5); set_alarm(1'b0);
      tick(5);
      check("R9 prescale0 held", throttle_req, 1);
      tick(2);
      check("R9 prescale0 released", throttle_req, 0);

      // R10 no hold
      cfg_hold_us = 12'd0; cfg_clk_per_us = 8'd3;
      set_alarm(1'b1); tick(5); set_alarm(1'b0);
      tick(1);
      check("R10 still active", throttle_req, 1);
      tick(1);
      check("R10 immediate release", throttle_req, 0);

      // R1 active-low polarity
      do_reset(1'b1);
      check("R12 reset low pol", event_count, 0);
      tick(5);
      check("R1 idle high pin", throttle_req, 0);
      alarm_pin = 1'b0; tick(3);
      check("R1 low pin alarm", throttle_req, 1);
      alarm_pin = 1'b1; tick(4);
      check("R1 low pol event", event_count, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule